// File: doc/BRIEF.md
# NAND Sector Hamming Syndrome Corrector

This block settles whether a 512-byte NAND sector read back from flash can be trusted, and repairs it when a single bit has flipped. The caller supplies two 3-byte Hamming codes with a one-cycle start strobe. The first code was stored in the spare area. The second was computed over the data just read. The block spreads each code into a 32-bit word and XORs the two words to form a syndrome. It then grades the syndrome by counting its set bits.

A done pulse marks the verdict. It comes with a 2-bit status, and for a repairable error also with the byte offset and bit position of the bad bit. The sector is then streamed through the block with a byte index. The one addressed byte comes out with its bad bit inverted, and every other byte passes unchanged.

Top module: `hecc_corrector`

## Requirements
- R1: Each 3-byte code {b2,b1,b0} is spread into a word as {4'h0, b2[7:4], b1, 4'h0, b2[3:0], b0}. The syndrome is the XOR of the two spread words. A zero syndrome gives status 0 (OK), with offset and bit both 0.
- R2: A syndrome with exactly twelve set bits gives status 1 (corrected). The offset is syndrome bits 27:19 and the bit index is syndrome bits 18:16.
- R3: While the status is 1, a stream byte whose index equals the offset leaves with bit `err_bit` inverted. Bytes with any other index leave unchanged.
- R4: A syndrome with exactly one set bit gives status 2 (code invalid), with offset and bit 0, and no stream byte is altered.
- R5: For any other nonzero syndrome, the status is 0 (erased page) when the spread stored word is 0x0fff0fff and the spread computed word is 0. This is the case for stored bytes FF,FF,FF and computed bytes 00,00,00.
- R6: Any other nonzero syndrome gives status 3 (uncorrectable), with offset and bit 0, and no stream byte is altered.
- R7: `done` is high for exactly one cycle, the second cycle after the one in which `start` was sampled. The status, offset and bit change only together with `done` and hold until the next verdict.
- R8: A synchronous active-high reset sets the status, offset and bit to 0 and drives `done` low.
- R9: The stream passes without storage: `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and `out_idx` follows `in_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that samples both codes |
| stored_code | input | 24 | Code read from the spare area, {b2,b1,b0} |
| calc_code | input | 24 | Code computed over the sector data, {b2,b1,b0} |
| done | output | 1 | One-cycle pulse when a verdict is ready |
| status | output | 2 | 0 OK, 1 corrected, 2 code invalid, 3 uncorrectable |
| err_offset | output | 9 | Byte offset of the bad bit |
| err_bit | output | 3 | Bit index of the bad bit within the byte |
| in_valid | input | 1 | Sector byte valid on the input side |
| in_ready | output | 1 | Input side may transfer |
| in_idx | input | 9 | Byte index of the input byte |
| in_data | input | 8 | Input sector byte |
| out_valid | output | 1 | Byte valid on the output side |
| out_ready | input | 1 | Downstream accepts the byte |
| out_idx | output | 9 | Byte index of the output byte |
| out_data | output | 8 | Output byte, repaired where required |

## Verification
The assertions assume that `start` pulses are at least three cycles apart, so a verdict is never overtaken inside the two-stage pipeline. They also assume that the stream is driven only after `done`, while the verdict is stable. Each bench scenario waits for the done pulse and one further cycle before it issues the next strobe, and it drives stream bytes only between verdicts. The twelve-bit syndromes are built from a chosen offset and bit with their complement in the low field, so the expected location is known before the run.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

    localparam int SECTOR_BYTES = 512;
    localparam int OFS_W        = $clog2(SECTOR_BYTES);
    localparam int BIT_W        = 3;
    localparam int SYN_W        = 32;
    localparam int FIX_WEIGHT   = 12;
    localparam int BAD_WEIGHT   = 1;
    localparam int BIT_LSB      = 16;
    localparam int OFS_LSB      = BIT_LSB + BIT_W;
    localparam logic [SYN_W-1:0] BLANK_STORED = 32'h0fff_0fff;

    typedef enum logic [1:0] {
        V_OK      = 2'd0,
        V_FIXED   = 2'd1,
        V_BADCODE = 2'd2,
        V_FATAL   = 2'd3
    } verdict_e;

    typedef struct packed {
        logic [7:0] b2;
        logic [7:0] b1;
        logic [7:0] b0;
    } code_t;

    typedef struct packed {
        verdict_e               verdict;
        logic [OFS_W-1:0]       offset;
        logic [BIT_W-1:0]       bitsel;
    } result_t;

    function automatic logic [SYN_W-1:0] spread_code(code_t c);
        return {4'h0, c.b2[7:4], c.b1, 4'h0, c.b2[3:0], c.b0};
    endfunction

endpackage

// File: rtl/hecc_popcnt.sv
module hecc_popcnt #(
    parameter int W  = 32,
    parameter int GW = 8,
    localparam int NG  = W / GW,
    localparam int GCW = $clog2(GW + 1),
    localparam int TW  = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          en,
    input  logic [W-1:0]  vec,
    output logic [TW-1:0] total
);
    logic [NG*GCW-1:0] parts_q;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        logic [GCW-1:0] cnt;
        always_comb begin
            cnt = '0;
            for (int i = 0; i < GW; i++)
                cnt = cnt + GCW'(vec[g*GW+i]);
        end
        always_ff @(posedge clk) begin
            if (en) parts_q[g*GCW +: GCW] <= cnt;
        end
    end

    always_comb begin
        total = '0;
        for (int g = 0; g < NG; g++)
            total = total + TW'(parts_q[g*GCW +: GCW]);
    end
endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
    import hecc_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  logic [SYN_W-1:0] syn,
    input  logic             blank,
    input  logic [TW-1:0]    total,
    output result_t          res_q,
    output logic             done_q
);
    result_t nxt;

    always_comb begin
        nxt = '0;
        if (total == TW'(0)) begin
            nxt.verdict = V_OK;
        end else if (total == TW'(FIX_WEIGHT)) begin
            nxt.verdict = V_FIXED;
            nxt.offset  = syn[OFS_LSB +: OFS_W];
            nxt.bitsel  = syn[BIT_LSB +: BIT_W];
        end else if (total == TW'(BAD_WEIGHT)) begin
            nxt.verdict = V_BADCODE;
        end else begin
            nxt.verdict = blank ? V_OK : V_FATAL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= vld;
            if (vld) res_q <= nxt;
        end
    end

    // R7
    held_between_verdicts_chk: assert property (@(posedge clk) disable iff (rst)
        (res_q != $past(res_q)) |-> done_q);

    // R8
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done_q && res_q == '0));

    // R2
    fixed_has_weight_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && total == TW'(FIX_WEIGHT)) |=> (res_q.verdict == V_FIXED));
endmodule

// File: rtl/hecc_flip.sv
module hecc_flip
    import hecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  result_t          res,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OFS_W-1:0] in_idx,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OFS_W-1:0] out_idx,
    output logic [7:0]       out_data
);
    logic [7:0] mask;

    always_comb begin
        mask = '0;
        if (res.verdict == V_FIXED && in_idx == res.offset)
            mask[res.bitsel] = 1'b1;
    end

    assign out_valid = in_valid;
    assign in_ready  = out_ready;
    assign out_idx   = in_idx;
    assign out_data  = in_data ^ mask;

    // R4 R6
    untouched_unless_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (out_data != in_data) |-> (res.verdict == V_FIXED));

    // R3
    single_bit_flip_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(out_data ^ in_data) <= 1);
endmodule

// File: rtl/hecc_corrector.sv
module hecc_corrector
    import hecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [23:0]      stored_code,
    input  logic [23:0]      calc_code,
    output logic             done,
    output logic [1:0]       status,
    output logic [OFS_W-1:0] err_offset,
    output logic [BIT_W-1:0] err_bit,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OFS_W-1:0] in_idx,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OFS_W-1:0] out_idx,
    output logic [7:0]       out_data
);
    localparam int TW = $clog2(SYN_W + 1);

    logic [SYN_W-1:0] st_w, ca_w, syn_d, syn_q;
    logic             blank_q, vld_q;
    logic [TW-1:0]    total;
    result_t          res;

    assign st_w  = spread_code(code_t'(stored_code));
    assign ca_w  = spread_code(code_t'(calc_code));
    assign syn_d = st_w ^ ca_w;

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= start;
        if (start) begin
            syn_q   <= syn_d;
            blank_q <= (st_w == BLANK_STORED) && (ca_w == '0);
        end
    end

    hecc_popcnt #(.W(SYN_W), .GW(8)) u_cnt (
        .clk(clk), .en(start), .vec(syn_d), .total(total)
    );

    hecc_classify #(.TW(TW)) u_cls (
        .clk(clk), .rst(rst), .vld(vld_q), .syn(syn_q), .blank(blank_q),
        .total(total), .res_q(res), .done_q(done)
    );

    hecc_flip u_flip (
        .clk(clk), .rst(rst), .res(res),
        .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx), .out_data(out_data)
    );

    assign status     = res.verdict;
    assign err_offset = res.offset;
    assign err_bit    = res.bitsel;

    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start, 2));
endmodule

// File: tb/sim_hecc_corrector.sv
module sim_hecc_corrector;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [23:0] stored_code = '0, calc_code = '0;
    logic done;
    logic [1:0] status;
    logic [8:0] err_offset;
    logic [2:0] err_bit;
    logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
    logic [8:0] in_idx = '0, out_idx;
    logic [7:0] in_data = '0, out_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    hecc_corrector u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] spread(input logic [23:0] c);
        return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
    endfunction

    // bytes {b2,b1,b0} whose difference gives syndrome {0,P,0,~P}, P={offset,bit}
    function automatic logic [23:0] fix_diff(input logic [8:0] o, input logic [2:0] b);
        logic [11:0] p = {o, b};
        logic [11:0] n = ~p;
        return {p[11:8], n[11:8], p[7:0], n[7:0]};
    endfunction

    task automatic run(input string req, input logic [23:0] st, input logic [23:0] ca,
                       input int ev, input int eo, input int eb);
        @(negedge clk);
        stored_code = st; calc_code = ca; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " R7 done early"}, done, 0);
        @(negedge clk);
        chk({req, " R7 done"}, done, 1);
        chk({req, " status"}, status, ev);
        chk({req, " offset"}, err_offset, eo);
        chk({req, " bit"}, err_bit, eb);
        @(negedge clk);
        chk({req, " R7 one pulse"}, done, 0);
        chk({req, " R7 hold"}, status, ev);
    endtask

    task automatic send(input string req, input logic [8:0] idx, input logic [7:0] d,
                        input logic [7:0] exp);
        @(negedge clk);
        in_valid = 1'b1; out_ready = 1'b1; in_idx = idx; in_data = d;
        #1;
        chk({req, " data"}, out_data, exp);
        chk("R9 valid", out_valid, 1);
        chk("R9 ready", in_ready, 1);
        chk("R9 idx", out_idx, idx);
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b0;
        #1;
        chk("R9 valid low", out_valid, 0);
        chk("R9 ready low", in_ready, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 done", done, 0);
        chk("R8 status", status, 0);
        chk("R8 offset", err_offset, 0);
        chk("R8 bit", err_bit, 0);
    endtask

    task automatic t_clean();
        run("R1 clean", 24'h3c_a5_17, 24'h3c_a5_17, 0, 0, 0);
        send("R1 no flip", 9'd0, 8'h55, 8'h55);
    endtask

    task automatic t_fix(input logic [8:0] o, input logic [2:0] b);
        logic [23:0] ca = 24'h5a_13_c7;
        run("R2 fix", ca ^ fix_diff(o, b), ca, 1, o, b);
        send("R3 target", o, 8'hf0, 8'hf0 ^ (8'h1 << b));
        send("R3 neighbour", o ^ 9'd1, 8'hf0, 8'hf0);
    endtask

    task automatic t_badcode();
        run("R4 one bit", 24'h00_00_10, 24'h00_00_00, 2, 0, 0);
        send("R4 untouched", 9'd0, 8'h81, 8'h81);
    endtask

    task automatic t_erased();
        run("R5 erased", 24'hff_ff_ff, 24'h00_00_00, 0, 0, 0);
        run("R6 near erased", 24'hff_ff_ff, 24'h00_00_01, 3, 0, 0);
    endtask

    task automatic t_fatal();
        run("R6 two bits", 24'h00_01_02, 24'h00_00_00, 3, 0, 0);
        send("R6 untouched", 9'd0, 8'h42, 8'h42);
        // twelve bits but not complementary still grades as fixed
        run("R2 raw weight", 24'h00_ff_0f, 24'h00_00_00, 1, 9'h1f, 3'h7);
    endtask

    initial begin
        t_reset();
        t_clean();
        t_fix(9'd0, 3'd0);
        t_fix(9'd511, 3'd7);
        t_fix(9'd300, 3'd5);
        t_badcode();
        t_erased();
        t_fatal();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule